// File: doc/BRIEF.md
# CPU Clock Source Selector and Divider

This block produces the clock enable that paces a CPU core. Two incoming clock streams, a crystal reference and a PLL output, are each given as one-cycle tick pulses on a fast system clock, so the whole path runs in a single clock domain. A source selector passes one of the two streams into a divider. The divider has four ratios: 1, 2, 3, or an even ratio of twice a programmable count N. An output selector then drives the CPU clock enable either from the divider or straight from the crystal stream.

Two control words, written and read over a simple register port, hold the selector bits, the divider code and N. Software retunes the PLL by first parking the output on the crystal, then moving the source selector to the PLL, and finally, once the PLL has settled, returning the output to the divider path. Every setting takes effect only at the edge of an output period, so a change never produces a shortened period.

Top module: `ckd_cpu_clk`

## Requirements
- R1: After reset both control words read as zero, and the CPU clock enable pulses once per crystal tick.
- R2: Word A at byte offset 0x00 holds N in bits 28:20. Word B at offset 0x40 holds the source bit in bit 0, the divider code in bits 3:2 and the output bit in bit 7. All other bits read zero, and any other offset reads zero.
- R3: Output bit 0 makes the CPU clock enable follow the crystal ticks. Output bit 1 makes it follow the divider.
- R4: Source bit 1 feeds the divider from the PLL ticks. Source bit 0 feeds it from the crystal ticks.
- R5: Divider codes 0, 1 and 2 give one output pulse every 1, 2 and 3 source ticks.
- R6: Divider code 3 gives one output pulse every 2*N source ticks.
- R7: With code 3 and N = 0, the divider produces no pulses. New settings then load without waiting for a pulse.
- R8: When a divider setting is written in the middle of a period, that period still ends at the old ratio, and the next period uses the new ratio.
- R9: An output-bit change takes effect at an output pulse. While the output is parked on the crystal, changes to the source and the divider leave the output period at one crystal tick. Switching back to the divider restarts its count.
- R10: A write to an unmapped offset changes no stored field and does not change the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xtal_tick_i | input | 1 | One-cycle pulse per crystal clock period |
| pll_tick_i | input | 1 | One-cycle pulse per PLL clock period |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (8) | Register byte offset |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for addr_i, combinational |
| cpu_clk_en_o | output | 1 | CPU clock enable, one pulse per output period |

## Verification
The bench builds the block with its default parameters: a 9-bit N at bit 20, both word offsets and all bit positions as in R2. The crystal tick period is 5 system cycles and the PLL tick period is 2. Because the two periods differ, the measured pulse spacing shows which source and which ratio are active. The default widths allow N values up to 511. The randomized ratios use N up to 24, which keeps every period well inside the run while the code-3 path is still exercised for many N values.

// File: rtl/ckd_pkg.sv
package ckd_pkg;

  // Divider code carried in the second control word
  typedef enum logic [1:0] {
    DSEL_BY1  = 2'd0,
    DSEL_BY2  = 2'd1,
    DSEL_BY3  = 2'd2,
    DSEL_BY2N = 2'd3
  } div_sel_e;

endpackage

// File: rtl/ckd_regs.sv
module ckd_regs
  import ckd_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int N_W     = 9,
  parameter int N_LSB   = 20,
  parameter int SEL_LSB = 2,
  parameter int OUT_BIT = 7,
  parameter int SRC_BIT = 0,
  parameter logic [ADDR_W-1:0] CFG_A_OFS = 8'h00,
  parameter logic [ADDR_W-1:0] CFG_B_OFS = 8'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_W-1:0]    n_o,
  output div_sel_e          sel_o,
  output logic              src_o,
  output logic              out_o
);

  logic [N_W-1:0] n_q, n_d;
  div_sel_e       sel_q, sel_d;
  logic           src_q, src_d;
  logic           out_q, out_d;
  logic           hit_a, hit_b;
  logic           unused_wdata;

  assign hit_a        = (addr_i == CFG_A_OFS);
  assign hit_b        = (addr_i == CFG_B_OFS);
  assign unused_wdata = ^wdata_i;

  always_comb begin
    n_d   = n_q;
    sel_d = sel_q;
    src_d = src_q;
    out_d = out_q;
    if (wr_en_i && hit_a) begin
      n_d = wdata_i[N_LSB +: N_W];
    end
    if (wr_en_i && hit_b) begin
      sel_d = div_sel_e'(wdata_i[SEL_LSB +: 2]);
      src_d = wdata_i[SRC_BIT];
      out_d = wdata_i[OUT_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= '0;
      sel_q <= DSEL_BY1;
      src_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      n_q   <= n_d;
      sel_q <= sel_d;
      src_q <= src_d;
      out_q <= out_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_a) begin
      rdata_o[N_LSB +: N_W] = n_q;
    end else if (hit_b) begin
      rdata_o[SEL_LSB +: 2] = sel_q;
      rdata_o[SRC_BIT]      = src_q;
      rdata_o[OUT_BIT]      = out_q;
    end
  end

  assign n_o   = n_q;
  assign sel_o = sel_q;
  assign src_o = src_q;
  assign out_o = out_q;

  // R2: a write to word B lands in the stored output bit
  a_r2_word_b_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_b) |=> (out_q == $past(wdata_i[OUT_BIT])));

  // R10: unmapped writes leave every field alone
  a_r10_unmapped_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit_a && !hit_b) |=>
      ($stable(n_q) && $stable(sel_q) && $stable(src_q) && $stable(out_q)));

endmodule

// File: rtl/ckd_divider.sv
module ckd_divider
  import ckd_pkg::*;
#(
  parameter int N_W = 9,
  localparam int CNT_W = N_W + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           xtal_tick_i,
  input  logic           pll_tick_i,
  input  logic [N_W-1:0] pend_n_i,
  input  div_sel_e       pend_sel_i,
  input  logic           pend_src_i,
  input  logic           restart_i,
  output logic           div_tick_o,
  output logic           idle_o
);

  logic [N_W-1:0]   act_n_q, act_n_d;
  div_sel_e         act_sel_q, act_sel_d;
  logic             act_src_q, act_src_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] ratio;
  logic             src_tick;
  logic             at_end;

  // Ratio of the active setting; zero marks a stopped divider
  always_comb begin
    if (act_sel_q == DSEL_BY2N) begin
      ratio = {act_n_q, 1'b0};
    end else begin
      ratio = CNT_W'({1'b0, act_sel_q}) + CNT_W'(1);
    end
  end

  assign idle_o     = (ratio == '0);
  assign src_tick   = act_src_q ? pll_tick_i : xtal_tick_i;
  assign at_end     = (cnt_q == (ratio - CNT_W'(1)));
  assign div_tick_o = !idle_o && src_tick && at_end;

  always_comb begin
    act_n_d   = act_n_q;
    act_sel_d = act_sel_q;
    act_src_d = act_src_q;
    cnt_d     = cnt_q;
    if (restart_i || idle_o || div_tick_o) begin
      act_n_d   = pend_n_i;
      act_sel_d = pend_sel_i;
      act_src_d = pend_src_i;
      cnt_d     = '0;
    end else if (src_tick) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_n_q   <= '0;
      act_sel_q <= DSEL_BY1;
      act_src_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      act_n_q   <= act_n_d;
      act_sel_q <= act_sel_d;
      act_src_q <= act_src_d;
      cnt_q     <= cnt_d;
    end
  end

  // R8: the active setting is frozen inside a running period
  a_r8_hold_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && !div_tick_o && !restart_i) |=>
      ($stable(act_n_q) && $stable(act_sel_q) && $stable(act_src_q)));

  // R5: a running count never passes the end of its period
  a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o |-> (cnt_q < ratio));

endmodule

// File: rtl/ckd_outmux.sv
module ckd_outmux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xtal_tick_i,
  input  logic div_tick_i,
  input  logic div_idle_i,
  input  logic pend_out_i,
  output logic restart_o,
  output logic cpu_en_o
);

  logic act_out_q, act_out_d;
  logic en_q, en_d;
  logic out_tick;
  logic may_switch;

  assign out_tick   = act_out_q ? div_tick_i : xtal_tick_i;
  // A stopped divider has no edge to wait for
  assign may_switch = out_tick || (act_out_q && div_idle_i);
  assign restart_o  = may_switch && !act_out_q && pend_out_i;

  always_comb begin
    act_out_d = act_out_q;
    if (may_switch) begin
      act_out_d = pend_out_i;
    end
    en_d = out_tick;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_out_q <= 1'b0;
      en_q      <= 1'b0;
    end else begin
      act_out_q <= act_out_d;
      en_q      <= en_d;
    end
  end

  assign cpu_en_o = en_q;

  // R9: the output path only changes at an output pulse or a stopped divider
  a_r9_switch_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_tick && !(act_out_q && div_idle_i)) |=> $stable(act_out_q));

  // R7: a stopped divider on the active path never pulses the output
  a_r7_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_out_q && div_idle_i) |=> !en_q);

endmodule

// File: rtl/ckd_cpu_clk.sv
module ckd_cpu_clk
  import ckd_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int N_W     = 9,
  parameter int N_LSB   = 20,
  parameter int SEL_LSB = 2,
  parameter int OUT_BIT = 7,
  parameter int SRC_BIT = 0,
  parameter logic [ADDR_W-1:0] CFG_A_OFS = 8'h00,
  parameter logic [ADDR_W-1:0] CFG_B_OFS = 8'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xtal_tick_i,
  input  logic              pll_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cpu_clk_en_o
);

  logic [1:0]     rst_sync_q;
  logic           rst_n;
  logic [N_W-1:0] pend_n;
  div_sel_e       pend_sel;
  logic           pend_src;
  logic           pend_out;
  logic           div_tick;
  logic           div_idle;
  logic           restart;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  ckd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_W(N_W), .N_LSB(N_LSB),
    .SEL_LSB(SEL_LSB), .OUT_BIT(OUT_BIT), .SRC_BIT(SRC_BIT),
    .CFG_A_OFS(CFG_A_OFS), .CFG_B_OFS(CFG_B_OFS)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .n_o     (pend_n),
    .sel_o   (pend_sel),
    .src_o   (pend_src),
    .out_o   (pend_out)
  );

  ckd_divider #(.N_W(N_W)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .xtal_tick_i (xtal_tick_i),
    .pll_tick_i  (pll_tick_i),
    .pend_n_i    (pend_n),
    .pend_sel_i  (pend_sel),
    .pend_src_i  (pend_src),
    .restart_i   (restart),
    .div_tick_o  (div_tick),
    .idle_o      (div_idle)
  );

  ckd_outmux u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .xtal_tick_i (xtal_tick_i),
    .div_tick_i  (div_tick),
    .div_idle_i  (div_idle),
    .pend_out_i  (pend_out),
    .restart_o   (restart),
    .cpu_en_o    (cpu_clk_en_o)
  );

endmodule

// File: tb/sim_ckd_cpu_clk.sv
module sim_ckd_cpu_clk;

  localparam int CLK_PERIOD = 10;
  localparam int XP         = 5;   // crystal tick period in system cycles
  localparam int PP         = 2;   // PLL tick period in system cycles
  localparam int LIMIT      = 4000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        xtal_tick, pll_tick;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        cpu_en;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ckd_cpu_clk u0 (
    .clk_i(clk), .rst_ni(rst_n), .xtal_tick_i(xtal_tick), .pll_tick_i(pll_tick),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .cpu_clk_en_o(cpu_en)
  );

  // Periodic source ticks
  initial begin
    int xc = 0;
    int pc = 0;
    xtal_tick = 1'b0;
    pll_tick  = 1'b0;
    forever begin
      @(negedge clk);
      xc = (xc + 1) % XP;
      pc = (pc + 1) % PP;
      xtal_tick = (xc == 0);
      pll_tick  = (pc == 0);
    end
  end

  function automatic int exp_gap(input bit src, input int sel, input int n);
    int r;
    r = (sel < 3) ? sel + 1 : 2 * n;
    return r * (src ? PP : XP);
  endfunction

  function automatic logic [31:0] word_b(input bit src, input int sel, input bit out);
    return (32'(out) << 7) | (32'(sel) << 2) | 32'(src);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_tick(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!cpu_en && gap < LIMIT);
  endtask

  task automatic steady(input string tag, input int exp);
    int g;
    repeat (3) wait_tick(g);
    wait_tick(g);
    chk(tag, g, exp);
  endtask

  task automatic set_cfg(input bit src, input int sel, input int n, input bit out);
    wr(8'h00, 32'(n) << 20);
    wr(8'h40, word_b(src, sel, out));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int g, cnt;
    void'($urandom(32'd4711));
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(8'h00, d); chk("R1 word A after reset", d, 0);
    rd(8'h40, d); chk("R1 word B after reset", d, 0);
    steady("R1 crystal pacing after reset", XP);

    // R2: field placement and read masking
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R2 word A mask", d, 32'h1FF0_0000);
    wr(8'h40, 32'hFFFF_FF7F);
    rd(8'h40, d); chk("R2 word B mask", d, 32'h0000_000D);
    rd(8'h20, d); chk("R2 unmapped read", d, 0);

    // R10: unmapped write
    set_cfg(1'b0, 1, 0, 1'b1);
    steady("R10 baseline", exp_gap(0, 1, 0));
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R10 word A kept", d, 0);
    rd(8'h40, d); chk("R10 word B kept", d, word_b(0, 1, 1));
    steady("R10 output kept", exp_gap(0, 1, 0));

    // R3: output bit 0 follows crystal regardless of divider
    set_cfg(1'b1, 2, 0, 1'b0);
    steady("R3 output on crystal", XP);

    // R5 / R4: fixed ratios from both sources
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 3; k++) begin
        set_cfg(s[0], k, 0, 1'b1);
        steady($sformatf("R5 R4 src%0d code%0d", s, k), exp_gap(s[0], k, 0));
      end
    end

    // R6: 2N ratio, directed edge and random
    set_cfg(1'b1, 3, 1, 1'b1);
    steady("R6 N=1 pll", exp_gap(1, 3, 1));
    for (int i = 0; i < 10; i++) begin
      bit s; int k, n;
      s = $urandom_range(1, 0);
      k = $urandom_range(3, 0);
      n = $urandom_range(24, 1);
      set_cfg(s, k, n, 1'b1);
      steady($sformatf("R6 R5 random src%0d code%0d n%0d", s, k, n), exp_gap(s, k, n));
    end

    // R7: code 3 with N=0 stops pulses, then recovers at once
    set_cfg(1'b0, 3, 0, 1'b1);
    repeat (40) @(negedge clk);
    cnt = 0;
    repeat (300) begin
      @(negedge clk);
      if (cpu_en) cnt++;
    end
    chk("R7 no pulses with N=0", cnt, 0);
    wr(8'h40, word_b(0, 0, 1));
    steady("R7 recovery to code 0", XP);

    // R8: mid-period write finishes the old period first
    set_cfg(1'b0, 2, 0, 1'b1);
    steady("R8 old ratio steady", 3 * XP);
    wait_tick(g);
    wr_en = 1'b1; addr = 8'h40; wdata = word_b(0, 1, 1);
    @(negedge clk);
    wr_en = 1'b0;
    g = 1;
    while (!cpu_en && g < LIMIT) begin
      @(negedge clk);
      g++;
    end
    chk("R8 period in progress keeps old ratio", g, 3 * XP);
    wait_tick(g);
    chk("R8 next period uses new ratio", g, 2 * XP);

    // R9: park-on-crystal retune sequence
    set_cfg(1'b1, 1, 0, 1'b1);
    steady("R9 running on pll", 2 * PP);
    wr(8'h40, word_b(1, 1, 0));
    steady("R9 parked", XP);
    wr(8'h40, word_b(0, 2, 0));
    steady("R9 parked, divider retuned", XP);
    wr(8'h40, word_b(1, 2, 0));
    steady("R9 parked, source to pll", XP);
    wr(8'h40, word_b(1, 2, 1));
    steady("R9 back on divider", 3 * PP);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule